// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches virtual-to-physical page mappings so that a translation can usually be done without walking the page table in memory. A 16-bit virtual address comes in on the lookup port. One cycle later the block reports either a hit, with a 16-bit physical address, or a miss. A miss has to be resolved through the page table, which costs extra memory accesses. An external walker does that work and then installs the result through the refill port. A single flush input drops every cached mapping in one cycle.

Pages are 256 bytes, so the low byte of an address is the page offset. That byte is copied unchanged into the physical address. The 8-bit virtual page number is split into two parts: its two low bits pick one of four sets, and its six upper bits are the tag compared inside that set. Each set has two ways, and both are compared at the same time. Each way stores a valid flag, a tag and the physical page number. When a set is full, a refill replaces the way that was used least recently.

Top module: `tlb_translator`

## Requirements
- R1: After reset, every entry is invalid. The outputs `lk_done`, `lk_hit` and `lk_paddr` are zero, and any lookup misses.
- R2: `lk_done` is high in the cycle after each cycle in which `lk_valid` is high, and it is low otherwise. `lk_hit` is never high while `lk_done` is low.
- R3: The lookup address is decoded as follows: bits [7:0] are the page offset, bits [9:8] are the set, and bits [15:10] are the tag. A hit requires an entry in that set that is valid and holds an equal tag. The same tag in another set does not match.
- R4: On a hit, `lk_paddr` equals the stored physical page number in bits [15:8] and the lookup's offset byte in bits [7:0].
- R5: On a miss, `lk_hit` is low and `lk_paddr` is zero.
- R6: One set holds two mappings with different tags at the same time, and both of them hit.
- R7: A refill goes into an invalid way of its set whenever one exists, so it evicts nothing.
- R8: In a full set, a refill replaces the least recently used way. Both a lookup hit and a refill mark their way as most recently used.
- R9: A refill whose page number already sits in its set overwrites that entry's physical page number and leaves the other way intact.
- R10: `flush_all` invalidates every entry at the next clock edge, and a lookup issued in the following cycle misses. A refill in the same cycle as `flush_all` is discarded.
- R11: A lookup sees the contents as they were before a refill in the same cycle. The lookup misses, and the same lookup issued one cycle later hits.
- R12: Refills into one set never change the mappings held in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 16 | Virtual address to translate |
| lk_done | output | 1 | Lookup result valid (one cycle after the request) |
| lk_hit | output | 1 | Result is a hit |
| lk_paddr | output | 16 | Translated physical address, zero on a miss |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 8 | Virtual page number of the mapping |
| fill_ppn | input | 8 | Physical page number of the mapping |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench drives the replacement order in a single set. A design that picked the wrong victim, or that did not update recency on a lookup hit, would lose the mapping that was just used and keep the stale one. It refills a page number that is already resident. A design without the match check would take the second way and leave a stale duplicate, and that stale copy would later evict a live mapping. The bench also issues a lookup and a refill of the same page in the same cycle, and a flush together with a refill. A design with the wrong ordering would report a hit that is too early, or would keep an entry that was meant to be flushed. Finally, it fills one set past its capacity while watching a neighbouring set. A design that decoded the set index wrongly would corrupt that neighbour.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // why a refill chose the way it writes
   typedef enum logic [1:0] {
      VSRC_MATCH = 2'd0,
      VSRC_FREE  = 2'd1,
      VSRC_REPL  = 2'd2
   } vsrc_e;

   function automatic logic is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tlb_way_array.sv
// One way of the buffer: per-set valid flag, tag and page number.
// Read port A serves lookups, read port B serves refill decisions.
module tlb_way_array #(
   parameter int SETS  = 4,
   parameter int TAG_W = 6,
   parameter int PPN_W = 8,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic [SET_W-1:0] rd_set_a,
   output logic             vld_a,
   output logic [TAG_W-1:0] tag_a,
   output logic [PPN_W-1:0] ppn_a,
   input  logic [SET_W-1:0] rd_set_b,
   output logic             vld_b,
   output logic [TAG_W-1:0] tag_b
);

   logic [SETS-1:0]             vld_q;
   logic [SETS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][PPN_W-1:0]  ppn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_set] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         tag_q[wr_set] <= wr_tag;
         ppn_q[wr_set] <= wr_ppn;
      end
   end

   assign vld_a = vld_q[rd_set_a];
   assign tag_a = tag_q[rd_set_a];
   assign ppn_a = ppn_q[rd_set_a];
   assign vld_b = vld_q[rd_set_b];
   assign tag_b = tag_q[rd_set_b];

endmodule

// File: rtl/tlb_match.sv
// Parallel tag compare across all ways of one set.
module tlb_match #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 6
) (
   input  logic [WAYS-1:0]             vld,
   input  logic [WAYS-1:0][TAG_W-1:0]  tags,
   input  logic [TAG_W-1:0]            key,
   output logic [WAYS-1:0]             hit_oh
);

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_oh[w] = vld[w] && (tags[w] == key);
   end

endmodule

// File: rtl/tlb_victim.sv
// Chooses the way a refill writes and keeps per-set replacement state.
// Two ways: one recency bit per set. More ways: round-robin pointer.
module tlb_victim #(
   parameter int SETS = 4,
   parameter int WAYS = 2,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_upd,
   input  logic [SET_W-1:0] hit_set,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAYS-1:0]  fill_match,
   input  logic [WAYS-1:0]  fill_vld,
   output logic [WAYS-1:0]  victim_oh
);
   import tlb_pkg::*;

   logic [WAYS-1:0]  free_oh;
   logic             free_any;
   logic [WAY_W-1:0] repl_cur;
   logic [WAY_W-1:0] vic_idx;
   vsrc_e            vsrc;

   always_comb begin
      free_oh  = '0;
      free_any = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (!fill_vld[w] && !free_any) begin
            free_oh[w] = 1'b1;
            free_any   = 1'b1;
         end
      end
   end

   always_comb begin
      if (|fill_match) begin
         vsrc      = VSRC_MATCH;
         victim_oh = fill_match;
      end else if (free_any) begin
         vsrc      = VSRC_FREE;
         victim_oh = free_oh;
      end else begin
         vsrc      = VSRC_REPL;
         victim_oh = '0;
         victim_oh[repl_cur] = 1'b1;
      end
   end

   always_comb begin
      vic_idx = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (victim_oh[w]) vic_idx = WAY_W'(w);
      end
   end

   if (WAYS == 2) begin : g_lru
      logic [SETS-1:0] lru_q;   // index of the least recently used way

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lru_q <= '0;
         end else begin
            for (int s = 0; s < SETS; s++) begin
               if (fill_en && fill_set == SET_W'(s))
                  lru_q[s] <= ~vic_idx[0];
               else if (hit_upd && hit_set == SET_W'(s))
                  lru_q[s] <= ~hit_way[0];
            end
         end
      end

      assign repl_cur = lru_q[fill_set];
   end else begin : g_rr
      logic [SETS-1:0][WAY_W-1:0] ptr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q <= '0;
         end else begin
            for (int s = 0; s < SETS; s++) begin
               if (fill_en && vsrc == VSRC_REPL && fill_set == SET_W'(s))
                  ptr_q[s] <= ptr_q[s] + 1'b1;
            end
         end
      end

      assign repl_cur = ptr_q[fill_set];
   end

endmodule

// File: rtl/tlb_translator.sv
module tlb_translator #(
   parameter int VA_W  = 16,
   parameter int PA_W  = 16,
   parameter int OFF_W = 8,
   parameter int SETS  = 4,
   parameter int WAYS  = 2,
   localparam int VPN_W = VA_W - OFF_W,
   localparam int PPN_W = PA_W - OFF_W,
   localparam int SET_W = $clog2(SETS),
   localparam int TAG_W = VPN_W - SET_W,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   output logic             lk_done,
   output logic             lk_hit,
   output logic [PA_W-1:0]  lk_paddr,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             flush_all
);

   // elaboration-time parameter checks
   if (!tlb_pkg::is_pow2(SETS) || SETS < 2) begin : g_bad_sets
      $error("tlb_translator: SETS must be a power of two, at least 2");
   end
   if (!tlb_pkg::is_pow2(WAYS) || WAYS < 2) begin : g_bad_ways
      $error("tlb_translator: WAYS must be a power of two, at least 2");
   end
   if (OFF_W < 1 || VPN_W <= SET_W || PPN_W < 1) begin : g_bad_widths
      $error("tlb_translator: address widths leave no tag or page number");
   end

   // address split
   logic [OFF_W-1:0] lk_off;
   logic [SET_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag;
   logic [SET_W-1:0] fl_set;
   logic [TAG_W-1:0] fl_tag;

   assign lk_off = lk_vaddr[OFF_W-1:0];
   assign lk_set = lk_vaddr[OFF_W +: SET_W];
   assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
   assign fl_set = fill_vpn[SET_W-1:0];
   assign fl_tag = fill_vpn[VPN_W-1 -: TAG_W];

   // storage
   logic                         fill_fire;
   logic [WAYS-1:0]              victim_oh;
   logic [WAYS-1:0]              vld_a, vld_b;
   logic [WAYS-1:0][TAG_W-1:0]   tag_a, tag_b;
   logic [WAYS-1:0][PPN_W-1:0]   ppn_a;

   assign fill_fire = fill_valid && !flush_all;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      tlb_way_array #(
         .SETS (SETS),
         .TAG_W(TAG_W),
         .PPN_W(PPN_W)
      ) u_arr (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (flush_all),
         .wr_en   (fill_fire && victim_oh[w]),
         .wr_set  (fl_set),
         .wr_tag  (fl_tag),
         .wr_ppn  (fill_ppn),
         .rd_set_a(lk_set),
         .vld_a   (vld_a[w]),
         .tag_a   (tag_a[w]),
         .ppn_a   (ppn_a[w]),
         .rd_set_b(fl_set),
         .vld_b   (vld_b[w]),
         .tag_b   (tag_b[w])
      );
   end

   // lookup compare and refill compare
   logic [WAYS-1:0] look_oh;
   logic [WAYS-1:0] fill_oh;

   tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_look_cmp (
      .vld   (vld_a),
      .tags  (tag_a),
      .key   (lk_tag),
      .hit_oh(look_oh)
   );

   tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_cmp (
      .vld   (vld_b),
      .tags  (tag_b),
      .key   (fl_tag),
      .hit_oh(fill_oh)
   );

   logic             look_hit;
   logic [PPN_W-1:0] look_ppn;
   logic [WAY_W-1:0] look_way;

   assign look_hit = |look_oh;

   always_comb begin
      look_ppn = '0;
      look_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (look_oh[w]) begin
            look_ppn = look_ppn | ppn_a[w];
            look_way = WAY_W'(w);
         end
      end
   end

   // replacement
   tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_upd   (lk_valid && look_hit),
      .hit_set   (lk_set),
      .hit_way   (look_way),
      .fill_en   (fill_fire),
      .fill_set  (fl_set),
      .fill_match(fill_oh),
      .fill_vld  (vld_b),
      .victim_oh (victim_oh)
   );

   // registered result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_done  <= 1'b0;
         lk_hit   <= 1'b0;
         lk_paddr <= '0;
      end else begin
         lk_done  <= lk_valid;
         lk_hit   <= lk_valid && look_hit;
         lk_paddr <= (lk_valid && look_hit) ? {look_ppn, lk_off} : '0;
      end
   end

endmodule

// File: rtl/tlb_translator_chk.sv
module tlb_translator_chk #(
   parameter int VA_W  = 16,
   parameter int PA_W  = 16,
   parameter int OFF_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic [VA_W-1:0] lk_vaddr,
   input logic            flush_all,
   input logic            lk_done,
   input logic            lk_hit,
   input logic [PA_W-1:0] lk_paddr
);

   // R2
   done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> lk_done);

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !lk_done);

   // R2
   hit_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_done);

   // R4
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (lk_hit |-> lk_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

   // R5
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && !lk_hit) |-> lk_paddr == '0);

   // R10
   flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush_all) && lk_valid) |=> !lk_hit);

endmodule

bind tlb_translator tlb_translator_chk #(
   .VA_W (VA_W),
   .PA_W (PA_W),
   .OFF_W(OFF_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_valid (lk_valid),
   .lk_vaddr (lk_vaddr),
   .flush_all(flush_all),
   .lk_done  (lk_done),
   .lk_hit   (lk_hit),
   .lk_paddr (lk_paddr)
);

// File: tb/sim_tlb_translator.sv
module sim_tlb_translator;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [15:0] lk_vaddr = '0;
   logic        lk_done, lk_hit;
   logic [15:0] lk_paddr;
   logic        fill_valid = 1'b0;
   logic [7:0]  fill_vpn = '0;
   logic [7:0]  fill_ppn = '0;
   logic        flush_all = 1'b0;

   int total = 0;
   int bad = 0;
   bit ended = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tlb_translator u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_valid  (lk_valid),
      .lk_vaddr  (lk_vaddr),
      .lk_done   (lk_done),
      .lk_hit    (lk_hit),
      .lk_paddr  (lk_paddr),
      .fill_valid(fill_valid),
      .fill_vpn  (fill_vpn),
      .fill_ppn  (fill_ppn),
      .flush_all (flush_all)
   );

   function automatic logic [15:0] va(input logic [5:0] tag, input logic [1:0] set,
                                      input logic [7:0] off);
      return {tag, set, off};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic look(input logic [15:0] a, output logic d, output logic h,
                       output logic [15:0] p);
      @(negedge clk);
      lk_valid = 1'b1;
      lk_vaddr = a;
      @(posedge clk);
      #1;
      d = lk_done; h = lk_hit; p = lk_paddr;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [5:0] tag, input logic [1:0] set, input logic [7:0] ppn);
      @(negedge clk);
      fill_valid = 1'b1;
      fill_vpn   = {tag, set};
      fill_ppn   = ppn;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic expect_hit(input logic [15:0] a, input logic [7:0] ppn, input string req);
      logic d, h;
      logic [15:0] p;
      look(a, d, h, p);
      check(d && h, req, {d, h}, 2'b11);
      check(p == {ppn, a[7:0]}, req, p, {ppn, a[7:0]});
   endtask

   task automatic expect_miss(input logic [15:0] a, input string req);
      logic d, h;
      logic [15:0] p;
      look(a, d, h, p);
      check(d && !h, req, {d, h}, 2'b10);
      check(p == 16'h0, req, p, 16'h0);
   endtask

   task automatic t_reset;
      #1;
      check(!lk_done && !lk_hit && lk_paddr == 0, "R1 reset outputs",
            {lk_done, lk_hit, lk_paddr}, 0);
      expect_miss(va(6'h1F, 2'd1, 8'h85), "R1 empty after reset");
   endtask

   task automatic t_basic;
      fill(6'h1F, 2'd1, 8'h80);
      expect_hit(va(6'h1F, 2'd1, 8'h85), 8'h80, "R4 hit address");
      // R2: done drops one cycle after the request is withdrawn
      @(posedge clk); #1;
      check(!lk_done, "R2 done single cycle", lk_done, 0);
      expect_miss(va(6'h1E, 2'd1, 8'h85), "R3 other tag same set");
      expect_miss(va(6'h1F, 2'd2, 8'h85), "R3 same tag other set");
      expect_miss(va(6'h00, 2'd0, 8'h00), "R5 miss zero");
   endtask

   task automatic t_twoway;
      fill(6'h05, 2'd2, 8'hA5);
      fill(6'h0A, 2'd2, 8'h5A);
      expect_hit(va(6'h05, 2'd2, 8'h01), 8'hA5, "R6 first way");
      expect_hit(va(6'h0A, 2'd2, 8'hFE), 8'h5A, "R6 second way");
   endtask

   task automatic t_lru;
      fill(6'h01, 2'd3, 8'h11);
      fill(6'h02, 2'd3, 8'h22);
      expect_hit(va(6'h01, 2'd3, 8'h10), 8'h11, "R8 touch first");
      fill(6'h03, 2'd3, 8'h33);
      expect_hit(va(6'h01, 2'd3, 8'h20), 8'h11, "R8 recent kept");
      expect_miss(va(6'h02, 2'd3, 8'h20), "R8 lru evicted");
      expect_hit(va(6'h03, 2'd3, 8'h30), 8'h33, "R8 new present");
      fill(6'h04, 2'd3, 8'h44);
      expect_hit(va(6'h04, 2'd3, 8'h40), 8'h44, "R8 second new");
      expect_hit(va(6'h03, 2'd3, 8'h41), 8'h33, "R8 hit keeps");
      expect_miss(va(6'h01, 2'd3, 8'h42), "R8 older evicted");
   endtask

   task automatic t_refresh;
      fill(6'h10, 2'd0, 8'h11);
      fill(6'h20, 2'd0, 8'h22);
      fill(6'h10, 2'd0, 8'h33);
      expect_hit(va(6'h10, 2'd0, 8'h07), 8'h33, "R9 updated ppn");
      expect_hit(va(6'h20, 2'd0, 8'h08), 8'h22, "R9 other way kept");
   endtask

   task automatic t_sets;
      fill(6'h30, 2'd0, 8'h90);
      fill(6'h31, 2'd0, 8'h91);
      fill(6'h32, 2'd0, 8'h92);
      expect_hit(va(6'h1F, 2'd1, 8'h33), 8'h80, "R12 set1 untouched");
      expect_hit(va(6'h32, 2'd0, 8'h34), 8'h92, "R12 set0 latest");
   endtask

   task automatic t_same_cycle;
      logic d, h;
      logic [15:0] p;
      @(negedge clk);
      lk_valid   = 1'b1;
      lk_vaddr   = va(6'h2A, 2'd1, 8'h66);
      fill_valid = 1'b1;
      fill_vpn   = {6'h2A, 2'd1};
      fill_ppn   = 8'h72;
      @(posedge clk); #1;
      d = lk_done; h = lk_hit; p = lk_paddr;
      @(negedge clk);
      lk_valid = 1'b0; fill_valid = 1'b0;
      check(d && !h && p == 0, "R11 same cycle miss", {d, h, p}, {2'b10, 16'h0});
      expect_hit(va(6'h2A, 2'd1, 8'h66), 8'h72, "R11 next cycle hit");
   endtask

   task automatic t_flush;
      @(negedge clk);
      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;
      expect_miss(va(6'h1F, 2'd1, 8'h85), "R10 flushed set1");
      expect_miss(va(6'h32, 2'd0, 8'h00), "R10 flushed set0");
      expect_miss(va(6'h05, 2'd2, 8'h00), "R10 flushed set2");
      expect_miss(va(6'h04, 2'd3, 8'h00), "R10 flushed set3");
      @(negedge clk);
      flush_all  = 1'b1;
      fill_valid = 1'b1;
      fill_vpn   = {6'h07, 2'd3};
      fill_ppn   = 8'h77;
      @(negedge clk);
      flush_all  = 1'b0;
      fill_valid = 1'b0;
      expect_miss(va(6'h07, 2'd3, 8'h00), "R10 fill with flush dropped");
   endtask

   task automatic t_after_flush;
      fill(6'h0C, 2'd2, 8'hC0);
      fill(6'h0D, 2'd2, 8'hD0);
      expect_hit(va(6'h0C, 2'd2, 8'h01), 8'hC0, "R7 free way one");
      expect_hit(va(6'h0D, 2'd2, 8'h02), 8'hD0, "R7 free way two");
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!ended) begin
         ended = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_twoway();
      t_lru();
      t_refresh();
      t_sets();
      t_same_cycle();
      t_flush();
      t_after_flush();
      repeat (2) @(negedge clk);
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule